// File: doc/BRIEF.md
# Sa-Bit Interrupt Controller

This block sits behind an E1 receive framer. Once per frame it takes the four national-use bits Sa5, Sa6, Sa7 and Sa8. It assembles one four-bit nibble per bit position over each submultiframe and turns changes in those bits and nibbles into interrupt events. It also counts how many Sa6 nibbles in a row carry the same pattern. Two further events come from a PRBS error checker: a single detection error, and the wrap of its 8-bit error counter.

Each of the seven sources has its own mask bit. A host writes the mask bits and a small control pair made of a suspend bit and an acknowledge bit. The controller drives one active-low request line with an output enable, so the pin can float, and a vector byte. Every source in the group shares the same vector value.

Top module: `sa_irq_ctrl`

## Requirements
- R1: With mask bit 0 set, a completed nibble (`sa_valid` and `nib_done` high together) whose value differs from the previous nibble of the same position, in any of the four positions, raises the request. The nibble is shifted in with the first received bit as MSB, and the bit of the completing frame is the LSB.
- R2: With mask bit 1 set, a frame (`sa_valid` high) whose `sa_bits` differ in any position from the previous frame's bits raises the request. `sa_bits[0]`=Sa5, `[1]`=Sa6, `[2]`=Sa7, `[3]`=Sa8.
- R3: Mask bit 2 enables an event for a change in the Sa6 nibble only. Mask bit 3 enables an event for a change in the Sa5 bit only. A change in other positions does not trigger either source.
- R4: With mask bit 4 set, the request is raised when the eighth Sa6 nibble in a row with the same pattern completes. The run restarts at one on a pattern change, and it does not fire again until the pattern has changed.
- R5: With mask bit 5 set, a `prbs_err` pulse raises the request. With mask bit 6 set, a `prbs_wrap` pulse raises it.
- R6: `irq_vec` reads 0x02 while a request is pending and 0x00 otherwise.
- R7: A write of `ctrl_wdata[0]` (acknowledge) that differs from its stored value, whether 0 to 1 or 1 to 0, clears the pending request so that `irq_n` goes high. An event accepted in the same cycle takes priority.
- R8: While the suspend bit (`ctrl_wdata[1]`) is one, `irq_oe` is low and events are dropped. They do not pend after suspend is cleared.
- R9: After reset, all mask bits, suspend and acknowledge are zero, `irq_n`=1, `irq_oe`=1 and `irq_vec`=0x00.
- R10: The request stays asserted from the first accepted event until acknowledged. Further events do not add a second pending request, so one acknowledge clears everything.
- R11: The first frame after reset only loads the stored bits, and the first completed nibble only loads the stored nibbles and starts the Sa6 run at one. Neither raises an event.
- R12: An event raises `irq_n` low on the clock edge that samples it. A mask or control write takes effect from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sa_valid | input | 1 | One-cycle strobe per received frame carrying Sa bits |
| sa_bits | input | 4 | Sa5..Sa8 of the current frame, bit 0 = Sa5 |
| nib_done | input | 1 | With sa_valid, marks the last frame of a nibble |
| prbs_err | input | 1 | Single PRBS detection error pulse |
| prbs_wrap | input | 1 | PRBS error counter wrap pulse |
| mask_we | input | 1 | Write strobe for the mask bits |
| mask_wdata | input | 7 | Mask bits, one per source (bit n enables source n) |
| ctrl_we | input | 1 | Write strobe for the control pair |
| ctrl_wdata | input | 2 | Bit 0 acknowledge, bit 1 suspend |
| irq_n | output | 1 | Interrupt request, active low |
| irq_oe | output | 1 | Output enable for irq_n, low = high impedance |
| irq_vec | output | 8 | Interrupt vector byte |

## Verification
The assertions assume that `nib_done` means something only together with `sa_valid`. They also assume that the only way to clear a pending request is a write whose acknowledge value differs from the stored one. The hold and clear properties are therefore stated against the controller's acceptance signal and its stored acknowledge bit, not against the raw source pulses. The stimulus always sends whole four-frame nibbles, so each nibble lines up with a submultiframe. Each acknowledge flips the bench's own copy of the bit, and suspend writes always carry the current acknowledge value. As a result, no clear happens by accident.

// File: rtl/sa_irq_pkg.sv
`timescale 1ns/1ps
// Package: source indices and shared types for the Sa-bit interrupt controller.
// Assumes: source order below matches the mask bit order written by the host.
package sa_irq_pkg;
    localparam int NSRC          = 7;
    localparam int SRC_NIB_ANY   = 0;
    localparam int SRC_BIT_ANY   = 1;
    localparam int SRC_NIB_SA6   = 2;
    localparam int SRC_BIT_SA5   = 3;
    localparam int SRC_RUN_SA6   = 4;
    localparam int SRC_PRBS_ERR  = 5;
    localparam int SRC_PRBS_WRAP = 6;
    typedef logic [NSRC-1:0] src_vec_t;
endpackage

// File: rtl/sa_change_det.sv
`timescale 1ns/1ps
// Module: sa_change_det
// Builds one nibble per Sa position from successive frames and flags bit
// and nibble changes against the previously stored values.
// Assumes: nib_done is only meaningful together with sa_valid; the first
// frame and the first nibble after reset only load the stored values.
module sa_change_det #(
    parameter int NPOS    = 4,
    parameter int NIB_W   = 4,
    parameter int SA5_IDX = 0,
    parameter int SA6_IDX = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sa_valid,
    input  logic            nib_done,
    input  logic [NPOS-1:0] sa_bits,
    output logic            nib_any_chg,
    output logic            bit_any_chg,
    output logic            sa6_nib_chg,
    output logic            sa5_bit_chg,
    output logic            sa6_tick,
    output logic            sa6_same
);
    logic            nib_strobe;
    logic            bit_seen_q;
    logic            nib_seen_q;
    logic [NPOS-1:0] bit_prev_q;
    logic [NPOS-1:0] nib_diff;

    assign nib_strobe = sa_valid & nib_done;

    // One shift register and stored nibble per Sa position.
    for (genvar p = 0; p < NPOS; p++) begin : g_pos
        logic [NIB_W-1:0] sh_q;
        logic [NIB_W-1:0] prev_q;
        logic [NIB_W-1:0] nib_new;

        assign nib_new     = {sh_q[NIB_W-2:0], sa_bits[p]};
        assign nib_diff[p] = (nib_new != prev_q);

        // Shift in the bit of each frame; capture the nibble on completion.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sh_q   <= '0;
                prev_q <= '0;
            end else if (sa_valid) begin
                sh_q <= nib_new;
                if (nib_done) prev_q <= nib_new;
            end
        end
    end

    // Remember last frame bits and whether the stored values are valid yet.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_prev_q <= '0;
            bit_seen_q <= 1'b0;
            nib_seen_q <= 1'b0;
        end else if (sa_valid) begin
            bit_prev_q <= sa_bits;
            bit_seen_q <= 1'b1;
            if (nib_done) nib_seen_q <= 1'b1;
        end
    end

    assign bit_any_chg = sa_valid & bit_seen_q & (sa_bits != bit_prev_q);
    assign sa5_bit_chg = sa_valid & bit_seen_q & (sa_bits[SA5_IDX] != bit_prev_q[SA5_IDX]);
    assign nib_any_chg = nib_strobe & nib_seen_q & (|nib_diff);
    assign sa6_nib_chg = nib_strobe & nib_seen_q & nib_diff[SA6_IDX];
    assign sa6_tick    = nib_strobe;
    assign sa6_same    = nib_seen_q & ~nib_diff[SA6_IDX];
endmodule

// File: rtl/sa6_run_cnt.sv
`timescale 1ns/1ps
// Module: sa6_run_cnt
// Counts completed Sa6 nibbles that repeat the previous pattern and pulses
// once when the run reaches RUN_LEN.
// Assumes: tick marks each completed nibble; same is low for the first one.
module sa6_run_cnt #(
    parameter int RUN_LEN = 8,
    localparam int CW     = $clog2(RUN_LEN + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic same,
    output logic run_hit
);
    logic [CW-1:0] cnt_q;

    // Restart at one on a new pattern, saturate at RUN_LEN.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (tick) begin
            if (!same)                       cnt_q <= CW'(1);
            else if (cnt_q < CW'(RUN_LEN))   cnt_q <= cnt_q + CW'(1);
        end
    end

    assign run_hit = tick & same & (cnt_q == CW'(RUN_LEN - 1));
endmodule

// File: rtl/irq_core.sv
`timescale 1ns/1ps
// Module: irq_core
// Holds mask and control bits, latches one pending request from masked
// events, and drives the request pin, its enable and the vector byte.
// Assumes: clear happens only when the written acknowledge bit differs
// from the stored one; an accepted event wins over a clear.
module irq_core
    import sa_irq_pkg::*;
#(
    parameter logic [7:0] VEC = 8'h02
) (
    input  logic       clk,
    input  logic       rst_n,
    input  src_vec_t   ev,
    input  logic       mask_we,
    input  src_vec_t   mask_wdata,
    input  logic       ctrl_we,
    input  logic [1:0] ctrl_wdata,
    output logic       irq_n,
    output logic       irq_oe,
    output logic [7:0] irq_vec,
    output logic       accept,
    output logic       ack_state
);
    src_vec_t   mask_q;
    logic       ack_q;
    logic       susp_q;
    logic       pend_q;
    logic [7:0] vec_q;
    logic       clr;
    logic       pend_nxt;

    assign accept   = (|(ev & mask_q)) & ~susp_q;
    assign clr      = ctrl_we & (ctrl_wdata[0] != ack_q);
    assign pend_nxt = accept | (pend_q & ~clr);

    // Host-written mask and control bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            ack_q  <= 1'b0;
            susp_q <= 1'b0;
        end else begin
            if (mask_we) mask_q <= mask_wdata;
            if (ctrl_we) begin
                ack_q  <= ctrl_wdata[0];
                susp_q <= ctrl_wdata[1];
            end
        end
    end

    // Pending request and the vector it reports.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            vec_q  <= '0;
        end else begin
            pend_q <= pend_nxt;
            vec_q  <= pend_nxt ? VEC : 8'h00;
        end
    end

    assign irq_n     = ~pend_q;
    assign irq_oe    = ~susp_q;
    assign irq_vec   = vec_q;
    assign ack_state = ack_q;
endmodule

// File: rtl/sa_irq_ctrl.sv
`timescale 1ns/1ps
// Module: sa_irq_ctrl (top)
// Sa-bit change, Sa6 run and PRBS interrupt controller.
// Assumes: frames arrive as sa_valid strobes; nibble boundaries are marked
// by nib_done on the last frame of each submultiframe.
module sa_irq_ctrl
    import sa_irq_pkg::*;
#(
    parameter int         NPOS    = 4,
    parameter int         NIB_W   = 4,
    parameter int         RUN_LEN = 8,
    parameter logic [7:0] VEC     = 8'h02
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sa_valid,
    input  logic [NPOS-1:0] sa_bits,
    input  logic            nib_done,
    input  logic            prbs_err,
    input  logic            prbs_wrap,
    input  logic            mask_we,
    input  logic [NSRC-1:0] mask_wdata,
    input  logic            ctrl_we,
    input  logic [1:0]      ctrl_wdata,
    output logic            irq_n,
    output logic            irq_oe,
    output logic [7:0]      irq_vec
);
    src_vec_t ev;
    logic     nib_any_chg, bit_any_chg, sa6_nib_chg, sa5_bit_chg;
    logic     sa6_tick, sa6_same, run_hit;
    logic     accept, ack_state;

    sa_change_det #(.NPOS(NPOS), .NIB_W(NIB_W), .SA5_IDX(0), .SA6_IDX(1)) u_det (
        .clk(clk), .rst_n(rst_n), .sa_valid(sa_valid), .nib_done(nib_done),
        .sa_bits(sa_bits), .nib_any_chg(nib_any_chg), .bit_any_chg(bit_any_chg),
        .sa6_nib_chg(sa6_nib_chg), .sa5_bit_chg(sa5_bit_chg),
        .sa6_tick(sa6_tick), .sa6_same(sa6_same)
    );

    sa6_run_cnt #(.RUN_LEN(RUN_LEN)) u_run (
        .clk(clk), .rst_n(rst_n), .tick(sa6_tick), .same(sa6_same), .run_hit(run_hit)
    );

    // Gather the seven sources in mask bit order.
    always_comb begin
        ev                = '0;
        ev[SRC_NIB_ANY]   = nib_any_chg;
        ev[SRC_BIT_ANY]   = bit_any_chg;
        ev[SRC_NIB_SA6]   = sa6_nib_chg;
        ev[SRC_BIT_SA5]   = sa5_bit_chg;
        ev[SRC_RUN_SA6]   = run_hit;
        ev[SRC_PRBS_ERR]  = prbs_err;
        ev[SRC_PRBS_WRAP] = prbs_wrap;
    end

    irq_core #(.VEC(VEC)) u_core (
        .clk(clk), .rst_n(rst_n), .ev(ev), .mask_we(mask_we), .mask_wdata(mask_wdata),
        .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .irq_n(irq_n), .irq_oe(irq_oe),
        .irq_vec(irq_vec), .accept(accept), .ack_state(ack_state)
    );
endmodule

// File: rtl/sa_irq_ctrl_chk.sv
`timescale 1ns/1ps
// Module: sa_irq_ctrl_chk
// Temporal checks on the request pin, vector, acknowledge and suspend.
// Assumes: bound into sa_irq_ctrl; accept and ack_state come from its core.
module sa_irq_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ctrl_we,
    input logic [1:0] ctrl_wdata,
    input logic       irq_n,
    input logic       irq_oe,
    input logic [7:0] irq_vec,
    input logic       accept,
    input logic       ack_state
);
    logic toggle;
    assign toggle = ctrl_we & (ctrl_wdata[0] != ack_state);

    AST_VEC_FOLLOWS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        irq_vec == (irq_n ? 8'h00 : 8'h02)); // R6
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (toggle && !accept) |=> irq_n); // R7
    AST_PEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_n && !toggle) |=> !irq_n); // R10
    AST_SUSP_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_we && ctrl_wdata[1]) |=> !irq_oe); // R8
    AST_SUSP_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_n && !irq_oe) |=> irq_n); // R8
    AST_ACCEPT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !irq_n); // R12
endmodule

bind sa_irq_ctrl sa_irq_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .irq_n(irq_n), .irq_oe(irq_oe), .irq_vec(irq_vec),
    .accept(accept), .ack_state(ack_state)
);

// File: tb/sa_irq_ctrl_bench.sv
`timescale 1ns/1ps
module sa_irq_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sa_valid = 1'b0;
    logic [3:0] sa_bits = '0;
    logic       nib_done = 1'b0;
    logic       prbs_err = 1'b0;
    logic       prbs_wrap = 1'b0;
    logic       mask_we = 1'b0;
    logic [6:0] mask_wdata = '0;
    logic       ctrl_we = 1'b0;
    logic [1:0] ctrl_wdata = '0;
    logic       irq_n, irq_oe;
    logic [7:0] irq_vec;

    always #2.5 clk = ~clk;

    sa_irq_ctrl u_sa_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .sa_valid(sa_valid), .sa_bits(sa_bits),
        .nib_done(nib_done), .prbs_err(prbs_err), .prbs_wrap(prbs_wrap),
        .mask_we(mask_we), .mask_wdata(mask_wdata), .ctrl_we(ctrl_we),
        .ctrl_wdata(ctrl_wdata), .irq_n(irq_n), .irq_oe(irq_oe), .irq_vec(irq_vec)
    );

    int    n_chk = 0;
    int    n_bad = 0;
    string cur_req = "R9";
    bit    started = 0;
    bit    done = 0;
    bit    ack_v = 0;
    bit    susp_v = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural reference model.
    int m_bp, m_sh[4], m_np[4], nn[4];
    int m_run, m_mask;
    bit m_bit_seen, m_nib_seen, m_pend, m_ack, m_susp;

    always @(posedge clk) begin
        int ev;
        bit clr;
        started <= 1;
        if (!rst_n) begin
            m_bp = 0; m_run = 0; m_mask = 0;
            m_bit_seen = 0; m_nib_seen = 0; m_pend = 0; m_ack = 0; m_susp = 0;
            for (int p = 0; p < 4; p++) begin m_sh[p] = 0; m_np[p] = 0; end
        end else begin
            ev = 0;
            if (sa_valid) begin
                if (m_bit_seen) begin
                    if (int'(sa_bits) != m_bp) ev |= 2;
                    if (int'(sa_bits[0]) != (m_bp & 1)) ev |= 8;
                end
                for (int p = 0; p < 4; p++) nn[p] = ((m_sh[p] << 1) | int'(sa_bits[p])) & 15;
                if (nib_done) begin
                    if (m_nib_seen) begin
                        for (int p = 0; p < 4; p++) if (nn[p] != m_np[p]) ev |= 1;
                        if (nn[1] != m_np[1]) ev |= 4;
                    end
                    if (m_nib_seen && nn[1] == m_np[1]) begin
                        if (m_run < 8) begin
                            m_run++;
                            if (m_run == 8) ev |= 16;
                        end
                    end else m_run = 1;
                    for (int p = 0; p < 4; p++) m_np[p] = nn[p];
                    m_nib_seen = 1;
                end
                for (int p = 0; p < 4; p++) m_sh[p] = nn[p];
                m_bp = int'(sa_bits);
                m_bit_seen = 1;
            end
            if (prbs_err) ev |= 32;
            if (prbs_wrap) ev |= 64;
            clr = ctrl_we && (ctrl_wdata[0] != m_ack);
            if (((ev & m_mask) != 0) && !m_susp) m_pend = 1;
            else if (clr) m_pend = 0;
            if (mask_we) m_mask = int'(mask_wdata);
            if (ctrl_we) begin m_ack = ctrl_wdata[0]; m_susp = ctrl_wdata[1]; end
        end
    end

    // Compare outputs with the model on every clock, away from the edge.
    always @(negedge clk) begin
        if (started && !done) begin
            chk(irq_n == !m_pend, cur_req, int'(irq_n), int'(!m_pend));
            chk(irq_oe == !m_susp, cur_req, int'(irq_oe), int'(!m_susp));
            chk(int'(irq_vec) == (m_pend ? 2 : 0), cur_req, int'(irq_vec), m_pend ? 2 : 0);
        end
    end

    task automatic send_nib(input logic [3:0] n5, input logic [3:0] n6,
                            input logic [3:0] n7, input logic [3:0] n8);
        for (int i = 3; i >= 0; i--) begin
            sa_valid = 1; nib_done = (i == 0);
            sa_bits  = {n8[i], n7[i], n6[i], n5[i]};
            @(negedge clk);
        end
        sa_valid = 0; nib_done = 0;
    endtask

    task automatic wr_mask(input logic [6:0] m);
        mask_we = 1; mask_wdata = m; @(negedge clk); mask_we = 0;
    endtask

    task automatic wr_ctrl();
        ctrl_we = 1; ctrl_wdata = {susp_v, ack_v}; @(negedge clk); ctrl_we = 0;
    endtask

    task automatic do_ack();
        ack_v = ~ack_v; wr_ctrl();
    endtask

    task automatic pulse(input bit wrap);
        if (wrap) prbs_wrap = 1; else prbs_err = 1;
        @(negedge clk); prbs_wrap = 0; prbs_err = 0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        cur_req = "R9";
        chk(irq_n == 1, "R9", int'(irq_n), 1);
        chk(irq_oe == 1, "R9", int'(irq_oe), 1);
        chk(irq_vec == 0, "R9", int'(irq_vec), 0);

        // Masks all clear: changes do nothing.
        cur_req = "R11";
        send_nib(4'h0, 4'h0, 4'h0, 4'h0);
        send_nib(4'h5, 4'h9, 4'h3, 4'hC);
        chk(irq_n == 1, "R9", int'(irq_n), 1);

        // Any-bit change.
        cur_req = "R2";
        wr_mask(7'h02);
        send_nib(4'hF, 4'h9, 4'h3, 4'hC);
        chk(irq_n == 0, "R2", int'(irq_n), 0);
        chk(irq_vec == 8'h02, "R6", int'(irq_vec), 2);
        cur_req = "R7";
        do_ack();
        chk(irq_n == 1, "R7", int'(irq_n), 1);
        chk(irq_vec == 8'h00, "R6", int'(irq_vec), 0);

        // Sa5-only bit change.
        cur_req = "R3";
        wr_mask(7'h08);
        send_nib(4'hF, 4'h6, 4'hC, 4'h3);
        chk(irq_n == 1, "R3", int'(irq_n), 1);
        send_nib(4'h0, 4'h6, 4'hC, 4'h3);
        chk(irq_n == 0, "R3", int'(irq_n), 0);
        do_ack();
        chk(irq_n == 1, "R7", int'(irq_n), 1);

        // Any-nibble change.
        cur_req = "R1";
        wr_mask(7'h01);
        send_nib(4'h0, 4'h6, 4'hC, 4'h3);
        chk(irq_n == 1, "R1", int'(irq_n), 1);
        send_nib(4'h0, 4'h6, 4'h5, 4'h3);
        chk(irq_n == 0, "R1", int'(irq_n), 0);
        do_ack();

        // Sa6-only nibble change.
        cur_req = "R3";
        wr_mask(7'h04);
        send_nib(4'h0, 4'h6, 4'hA, 4'h3);
        chk(irq_n == 1, "R3", int'(irq_n), 1);
        send_nib(4'h0, 4'h3, 4'hA, 4'h3);
        chk(irq_n == 0, "R3", int'(irq_n), 0);
        do_ack();

        // Sa6 run of eight: run is at one now.
        cur_req = "R4";
        wr_mask(7'h10);
        for (int k = 0; k < 6; k++) send_nib(4'h0, 4'h3, 4'hA, 4'h3);
        chk(irq_n == 1, "R4", int'(irq_n), 1);
        send_nib(4'h0, 4'h3, 4'hA, 4'h3);
        chk(irq_n == 0, "R4", int'(irq_n), 0);
        do_ack();
        for (int k = 0; k < 3; k++) send_nib(4'h0, 4'h3, 4'hA, 4'h3);
        chk(irq_n == 1, "R4", int'(irq_n), 1);
        send_nib(4'h0, 4'h5, 4'hA, 4'h3);
        chk(irq_n == 1, "R4", int'(irq_n), 1);

        // PRBS sources.
        cur_req = "R5";
        wr_mask(7'h20);
        pulse(1);
        chk(irq_n == 1, "R5", int'(irq_n), 1);
        pulse(0);
        chk(irq_n == 0, "R5", int'(irq_n), 0);
        do_ack();
        wr_mask(7'h40);
        pulse(1);
        chk(irq_n == 0, "R5", int'(irq_n), 0);
        do_ack();
        chk(irq_n == 1, "R7", int'(irq_n), 1);

        // Suspend.
        cur_req = "R8";
        wr_mask(7'h7F);
        susp_v = 1; wr_ctrl();
        chk(irq_oe == 0, "R8", int'(irq_oe), 0);
        pulse(0);
        susp_v = 0; wr_ctrl();
        chk(irq_n == 1, "R8", int'(irq_n), 1);
        chk(irq_oe == 1, "R8", int'(irq_oe), 1);

        // Single pending, held until one acknowledge.
        cur_req = "R10";
        pulse(0);
        chk(irq_n == 0, "R12", int'(irq_n), 0);
        pulse(1);
        repeat (3) @(negedge clk);
        chk(irq_n == 0, "R10", int'(irq_n), 0);
        do_ack();
        chk(irq_n == 1, "R10", int'(irq_n), 1);

        // First frame and nibble after reset only initialize.
        cur_req = "R11";
        rst_n = 0; repeat (2) @(negedge clk); rst_n = 1;
        ack_v = 0; susp_v = 0;
        wr_mask(7'h7F);
        send_nib(4'hF, 4'hF, 4'hF, 4'hF);
        chk(irq_n == 1, "R11", int'(irq_n), 1);
        send_nib(4'hF, 4'hF, 4'hF, 4'hF);
        chk(irq_n == 1, "R11", int'(irq_n), 1);
        send_nib(4'hF, 4'hF, 4'hF, 4'hE);
        chk(irq_n == 0, "R1", int'(irq_n), 0);
        do_ack();
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule